// File: doc/BRIEF.md
# Post-Transmit Transceiver Heartbeat Checker

After every transmitted frame, a healthy transceiver briefly asserts its collision-indication line. This pulse is the signal-quality heartbeat. The block checks for it. When transmit-enable falls, it opens an observation window of fixed length. The window is counted in ticks of a time base that the surrounding logic supplies. The block watches the synchronised collision input throughout the window.

When the window closes, the block updates one status bit. The bit clears if a heartbeat was seen and sets if none was seen. It then holds that value until the next window closes. A second output shows while a window is open. If a new transmission starts during an open window, the window is abandoned and the status keeps its old value.

The default length is 36 ticks. With a 100 ns tick (one bit time at 10 Mb/s), this gives a 3.6 µs window.

Top module: `sqe_watch`

## Requirements
- R1: After reset is released, `hb_missing_o` and `win_active_o` are both 0.
- R2: `win_active_o` goes to 1 on the clock edge that follows the first edge on which `tx_en_i` is sampled 0 after being sampled 1.
- R3: An open window closes (`win_active_o` goes to 0) on the edge that samples the `WIN_TICKS`-th high `tick_i` counted from the edge after the window opened. It is never open for more than `WIN_TICKS` ticks.
- R4: `col_i` passes through `SYNC_STAGES` flip-flops (2 by default). If any high level of the synchronised signal is sampled on the edges while the window is open, including the closing edge, `hb_missing_o` becomes 0 at close.
- R5: If no high level of the synchronised collision signal is sampled during the window, `hb_missing_o` becomes 1 at close.
- R6: `hb_missing_o` changes only on the edge where a window closes. At all other times it holds its value.
- R7: If `tx_en_i` is sampled 1 while a window is open, the window ends on that edge and `hb_missing_o` keeps its previous value.
- R8: Collision pulses whose synchronised level falls wholly before the window opens, or wholly after it closes, have no effect on `hb_missing_o`.
- R9: Clock edges on which `tick_i` is 0 do not advance the window. The window stays open across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; its falling edge opens a window |
| col_i | input | 1 | Collision indication from the transceiver, asynchronous |
| tick_i | input | 1 | Time-base tick, one cycle wide, that advances the window |
| hb_missing_o | output | 1 | 1 when the last completed window saw no heartbeat |
| win_active_o | output | 1 | 1 while an observation window is open |

## Verification
The bench sweeps a single-cycle collision pulse across every offset from well before the transmit end to past the window close. The expected status comes from the two-stage synchroniser delay and the window bounds. This separates pulses that count from pulses that fall just outside the window on either side. The same sweep is repeated with a sparse tick. That version checks that the window length follows ticks and not cycles. Further runs raise transmit-enable partway through a window after a pulse has already been seen. They check that the window is cancelled and that the status keeps its old value rather than taking the pending result.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  // 3.6 us at a 100 ns (bit-time) tick
  localparam int unsigned DEF_WIN_TICKS   = 36;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic open;
    logic cancel;
    logic close;
  } win_evt_t;
endpackage

// File: rtl/sqe_sync.sv
module sqe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sqe_win_timer.sv
module sqe_win_timer
  import sqe_pkg::*;
#(
  parameter int unsigned WIN_TICKS = DEF_WIN_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic active_o,
  output logic close_o
);
  localparam int unsigned CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             last_tick;

  assign last_tick = tick_i && (cnt_q == LAST);
  assign close_o   = active_q && !cancel_i && last_tick;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (open_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cancel_i || last_tick) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqe_status.sv
module sqe_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic active_i,
  input  logic close_i,
  input  logic col_s_i,
  output logic missing_o
);
  logic seen_q;
  logic missing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else if (open_i) begin
      seen_q <= 1'b0;
    end else if (active_i && col_s_i) begin
      seen_q <= 1'b1;
    end
  end

  // level on the closing edge still counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      missing_q <= 1'b0;
    else if (close_i) missing_q <= !(seen_q || col_s_i);
  end

  assign missing_o = missing_q;
endmodule

// File: rtl/sqe_watch.sv
module sqe_watch
  import sqe_pkg::*;
#(
  parameter int unsigned WIN_TICKS   = DEF_WIN_TICKS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic col_i,
  input  logic tick_i,
  output logic hb_missing_o,
  output logic win_active_o
);
  logic     tx_q;
  logic     col_s;
  logic     active;
  win_evt_t evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b0;
    else         tx_q <= tx_en_i;
  end

  assign evt.open   = tx_q && !tx_en_i;
  assign evt.cancel = tx_en_i;

  sqe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (col_i),
    .q_o    (col_s)
  );

  sqe_win_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (evt.open),
    .cancel_i (evt.cancel),
    .tick_i   (tick_i),
    .active_o (active),
    .close_o  (evt.close)
  );

  sqe_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (evt.open),
    .active_i  (active),
    .close_i   (evt.close),
    .col_s_i   (col_s),
    .missing_o (hb_missing_o)
  );

  assign win_active_o = active;
endmodule

// File: rtl/sqe_watch_chk.sv
module sqe_watch_chk #(
  parameter int unsigned WIN_TICKS = 36
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic tick_i,
  input logic hb_missing_o,
  input logic win_active_o
);
  localparam int unsigned CW = $clog2(WIN_TICKS + 1);

  logic [CW-1:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ticks_q <= '0;
    else if (!win_active_o)                   ticks_q <= '0;
    else if (tick_i && ticks_q != CW'(WIN_TICKS)) ticks_q <= ticks_q + 1'b1;
  end

  // R2
  open_after_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_en_i) && !tx_en_i) |=> win_active_o);

  // R3
  win_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_active_o |-> (ticks_q < CW'(WIN_TICKS)));

  // R6
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_active_o |=> $stable(hb_missing_o));

  // R7
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_active_o && tx_en_i) |=> (!win_active_o && $stable(hb_missing_o)));

  // R9
  no_tick_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_active_o && !tick_i && !tx_en_i) |=> win_active_o);
endmodule

bind sqe_watch sqe_watch_chk #(.WIN_TICKS(WIN_TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_i      (tx_en_i),
  .tick_i       (tick_i),
  .hb_missing_o (hb_missing_o),
  .win_active_o (win_active_o)
);

// File: tb/sqe_watch_tb_top.sv
module sqe_watch_tb_top;
  localparam int W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en_i = 1'b0;
  logic col_i = 1'b0;
  logic tick_i = 1'b0;
  logic hb_missing_o;
  logic win_active_o;

  int n_chk = 0;
  int n_fail = 0;
  bit hb_prev = 1'b0;

  always #5 clk_i = ~clk_i;

  sqe_watch #(.WIN_TICKS(W), .SYNC_STAGES(2)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_en_i      (tx_en_i),
    .col_i        (col_i),
    .tick_i       (tick_i),
    .hb_missing_o (hb_missing_o),
    .win_active_o (win_active_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // d: offset of one-cycle col pulse; per: tick period; cj: cancel offset (-1 none)
  task automatic run_window(input int d, input int per, input int cj);
    int jc = 0;
    int nt = 0;
    bit exp_hb;
    bit in_win;
    for (int j = 1; j < 1000; j++) begin
      if (j % per == 0) nt++;
      if (nt == W) begin jc = j; break; end
    end
    // synchronised level reaches logic at edge A+d+2
    in_win = (d + 2 >= 1) && (d + 2 <= ((cj >= 0) ? cj : jc));
    exp_hb = (cj >= 0) ? hb_prev : !in_win;
    for (int j = -5; j <= jc + 3; j++) begin
      @(negedge clk_i);
      if (j >= 1)
        check((cj >= 0) ? "R7 active" : "R2/R3/R9 active", win_active_o,
              (cj >= 0) ? (j <= cj) : (j <= jc));
      if (j >= 1 && j <= jc && cj < 0)
        check("R6 hold", hb_missing_o, hb_prev);
      if (j == jc + 1)
        check((cj >= 0) ? "R7 status" : (in_win ? "R4 status" : "R5/R8 status"),
              hb_missing_o, exp_hb);
      tx_en_i = (j < 0) || (cj >= 0 && j >= cj);
      col_i   = (j == d);
      tick_i  = (j % per == 0);
    end
    hb_prev = exp_hb;
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 hb", hb_missing_o, 1'b0);
    check("R1 active", win_active_o, 1'b0);
    // every offset, tick each cycle, then sparse tick
    for (int d = -4; d <= W + 1; d++) run_window(d, 1, -1);
    for (int d = -4; d <= 3 * W + 1; d++) run_window(d, 3, -1);
    // cancel after a heartbeat has been seen, status must not clear
    run_window(W + 3, 1, -1);
    run_window(0, 1, 3);
    run_window(-1, 3, 5);
    run_window(0, 1, -1);
    run_window(W + 3, 1, 2);
    // idle: status must stay put
    tx_en_i = 1'b0;
    col_i   = 1'b1;
    repeat (10) @(negedge clk_i);
    check("R8 idle hb", hb_missing_o, hb_prev);
    check("R8 idle active", win_active_o, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule